// File: doc/BRIEF.md
# Function-Group Pad Multiplexer

This block sits in front of a contiguous bank of 27 pads (pins 72 to 98) and decides, pad by pad, whether the pad belongs to plain GPIO or to one of three fixed function groups: a serial-flash group that can be placed on either of two pad sets, a UART0 transmit/receive pair, and a ten-pin eMMC group. Three control inputs pick the groups. They are captured in a register that resets to "everything disabled", so after reset every pad is driven from the GPIO output and output-enable vectors.

For every pad the block forwards the output data and output enable of whichever owner holds it, and reports that owner as a 2-bit code. The pad input data is routed back to the function that owns the pad. The second flash pad set shares four pads with the eMMC group. When both are enabled, eMMC keeps those pads, the flash group is left without any pads, and a status output flags the conflict.

Top module: `fgroup_padmux`

## Requirements
- R1: While reset is held and after it is released, before any group is enabled, every pad owner code is 0 (GPIO), every pad follows gpio_do/gpio_oe, and overlap is 0.
- R2: The control inputs flash_sel, uart_sel and emmc_sel take effect one clock edge after they are sampled. The outputs reflect the values registered at the most recent rising edge.
- R3: With flash_sel = 1, pins 83, 84, 86 and 87 (pad indices 11, 12, 14, 15) carry flash_do/flash_oe bits 0..3 in ascending pin order, with owner code 1. flash_di[k] returns the pad input of the k-th of those pins.
- R4: With flash_sel = 2, pins 76, 78, 79 and 81 (pad indices 4, 6, 7, 9) carry flash bits 0..3 in ascending pin order, with owner code 1, unless eMMC is also enabled.
- R5: flash_sel values 0 and 3 disable the flash group: no pad has owner code 1, and flash_di is all zero.
- R6: With uart_sel = 1, pin 88 (pad 16) drives uart_tx with output enable forced to 1, and pin 89 (pad 17) has output enable forced to 0 and data 0. Both pads have owner code 2. uart_rx returns pad 17's input while the group is active and reads 1 otherwise.
- R7: With emmc_sel = 1, pins 72 to 81 (pad indices 0..9) carry emmc_do/emmc_oe bit k on pin 72+k, with owner code 3. emmc_di returns those pad inputs. emmc_di is zero while the group is inactive.
- R8: When emmc_sel = 1 and flash_sel = 2, eMMC owns pins 76, 78, 79 and 81, overlap is 1 and flash_di is zero. overlap is 0 in every other combination.
- R9: A pad that no active group claims has owner code 0 and drives gpio_do/gpio_oe of its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flash_sel | input | 2 | Flash group placement: 1 = high pad set, 2 = low pad set, 0/3 = off |
| uart_sel | input | 1 | UART0 pair enable |
| emmc_sel | input | 1 | eMMC group enable |
| gpio_do | input | 27 | GPIO output data per pad |
| gpio_oe | input | 27 | GPIO output enable per pad |
| flash_do | input | 4 | Flash function output data |
| flash_oe | input | 4 | Flash function output enable |
| uart_tx | input | 1 | UART0 transmit data |
| emmc_do | input | 10 | eMMC function output data |
| emmc_oe | input | 10 | eMMC function output enable |
| pad_di | input | 27 | Input data from the pads |
| pad_do | output | 27 | Output data to the pads |
| pad_oe | output | 27 | Output enable to the pads |
| pad_owner | output | 54 | 2-bit owner code per pad, pad p at bits 2p+1:2p (0 GPIO, 1 flash, 2 UART0, 3 eMMC) |
| flash_di | output | 4 | Pad inputs returned to the flash function |
| uart_rx | output | 1 | Pad input returned as UART0 receive data |
| emmc_di | output | 10 | Pad inputs returned to the eMMC function |
| overlap | output | 1 | eMMC and the low flash pad set are both enabled |

## Verification
A corrupted control register shows up as wrong owner codes on whole groups of pads. This happens in the cycle after the control inputs were sampled, because the owner codes are decoded from the register with no further delay. A wrong priority between eMMC and the low flash set shows only on the four shared pads and on overlap, and only when both groups are enabled together, so stimulus must hit that combination often. A swapped bit order within a group appears at once as the wrong function bit on a pad, which is visible only when the function's data bits differ from one another.

// File: rtl/fgroup_padmux.sv
module fgroup_padmux #(
  parameter int PIN_BASE = 72,
  parameter int NPAD     = 27,
  parameter int FLASH_W  = 4,
  parameter int EMMC_W   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           flash_sel,
  input  logic                 uart_sel,
  input  logic                 emmc_sel,
  input  logic [NPAD-1:0]      gpio_do,
  input  logic [NPAD-1:0]      gpio_oe,
  input  logic [FLASH_W-1:0]   flash_do,
  input  logic [FLASH_W-1:0]   flash_oe,
  input  logic                 uart_tx,
  input  logic [EMMC_W-1:0]    emmc_do,
  input  logic [EMMC_W-1:0]    emmc_oe,
  input  logic [NPAD-1:0]      pad_di,
  output logic [NPAD-1:0]      pad_do,
  output logic [NPAD-1:0]      pad_oe,
  output logic [2*NPAD-1:0]    pad_owner,
  output logic [FLASH_W-1:0]   flash_di,
  output logic                 uart_rx,
  output logic [EMMC_W-1:0]    emmc_di,
  output logic                 overlap
);
  localparam logic [1:0] OWN_GPIO  = 2'd0;
  localparam logic [1:0] OWN_FLASH = 2'd1;
  localparam logic [1:0] OWN_UART  = 2'd2;
  localparam logic [1:0] OWN_EMMC  = 2'd3;

  localparam int FLASH_HI [FLASH_W] = '{83 - PIN_BASE, 84 - PIN_BASE, 86 - PIN_BASE, 87 - PIN_BASE};
  localparam int FLASH_LO [FLASH_W] = '{76 - PIN_BASE, 78 - PIN_BASE, 79 - PIN_BASE, 81 - PIN_BASE};
  localparam int EMMC_FIRST = 72 - PIN_BASE;
  localparam int UART_TXP   = 88 - PIN_BASE;
  localparam int UART_RXP   = 89 - PIN_BASE;

  logic [1:0] fsel_q;
  logic       uart_q, emmc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= 2'd0;
      uart_q <= 1'b0;
      emmc_q <= 1'b0;
    end else begin
      fsel_q <= flash_sel;
      uart_q <= uart_sel;
      emmc_q <= emmc_sel;
    end
  end

  logic flash_hi_on, flash_lo_req, flash_lo_on;
  assign flash_hi_on  = (fsel_q == 2'd1);
  assign flash_lo_req = (fsel_q == 2'd2);
  assign flash_lo_on  = flash_lo_req & ~emmc_q;
  assign overlap      = flash_lo_req & emmc_q;

  always_comb begin
    pad_do    = gpio_do;
    pad_oe    = gpio_oe;
    pad_owner = '0;
    for (int k = 0; k < FLASH_W; k++) begin
      if (flash_hi_on) begin
        pad_do[FLASH_HI[k]]          = flash_do[k];
        pad_oe[FLASH_HI[k]]          = flash_oe[k];
        pad_owner[2*FLASH_HI[k] +: 2] = OWN_FLASH;
      end
      if (flash_lo_on) begin
        pad_do[FLASH_LO[k]]          = flash_do[k];
        pad_oe[FLASH_LO[k]]          = flash_oe[k];
        pad_owner[2*FLASH_LO[k] +: 2] = OWN_FLASH;
      end
    end
    if (emmc_q) begin
      for (int j = 0; j < EMMC_W; j++) begin
        pad_do[EMMC_FIRST+j]             = emmc_do[j];
        pad_oe[EMMC_FIRST+j]             = emmc_oe[j];
        pad_owner[2*(EMMC_FIRST+j) +: 2] = OWN_EMMC;
      end
    end
    if (uart_q) begin
      pad_do[UART_TXP]             = uart_tx;
      pad_oe[UART_TXP]             = 1'b1;
      pad_owner[2*UART_TXP +: 2]   = OWN_UART;
      pad_do[UART_RXP]             = 1'b0;
      pad_oe[UART_RXP]             = 1'b0;
      pad_owner[2*UART_RXP +: 2]   = OWN_UART;
    end
  end

  always_comb begin
    for (int k = 0; k < FLASH_W; k++) begin
      if (flash_hi_on)      flash_di[k] = pad_di[FLASH_HI[k]];
      else if (flash_lo_on) flash_di[k] = pad_di[FLASH_LO[k]];
      else                  flash_di[k] = 1'b0;
    end
  end

  assign emmc_di = emmc_q ? pad_di[EMMC_FIRST +: EMMC_W] : '0;
  assign uart_rx = uart_q ? pad_di[UART_RXP] : 1'b1;

  logic unused_ok;
  assign unused_ok = (OWN_GPIO == 2'd0);
endmodule

// File: rtl/fgroup_padmux_chk.sv
module fgroup_padmux_chk #(
  parameter int PIN_BASE = 72,
  parameter int NPAD     = 27,
  parameter int FLASH_W  = 4,
  parameter int EMMC_W   = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           flash_sel,
  input logic                 uart_sel,
  input logic                 emmc_sel,
  input logic [NPAD-1:0]      gpio_do,
  input logic [NPAD-1:0]      gpio_oe,
  input logic [FLASH_W-1:0]   flash_do,
  input logic [FLASH_W-1:0]   flash_oe,
  input logic                 uart_tx,
  input logic [EMMC_W-1:0]    emmc_do,
  input logic [EMMC_W-1:0]    emmc_oe,
  input logic [NPAD-1:0]      pad_di,
  input logic [NPAD-1:0]      pad_do,
  input logic [NPAD-1:0]      pad_oe,
  input logic [2*NPAD-1:0]    pad_owner,
  input logic [FLASH_W-1:0]   flash_di,
  input logic                 uart_rx,
  input logic [EMMC_W-1:0]    emmc_di,
  input logic                 overlap
);
  localparam int EM0 = 72 - PIN_BASE;
  localparam int FH0 = 83 - PIN_BASE;
  localparam int FL0 = 76 - PIN_BASE;
  localparam int TXP = 88 - PIN_BASE;
  localparam int RXP = 89 - PIN_BASE;

  assert_reset_gpio_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_owner == '0 && !overlap));

  assert_emmc_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emmc_sel |=> pad_owner[2*EM0 +: 2] == 2'd3);

  assert_flash_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sel == 2'd1 |=> pad_owner[2*FH0 +: 2] == 2'd1);

  assert_flash_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_sel == 2'd2 && !emmc_sel) |=> pad_owner[2*FL0 +: 2] == 2'd1);

  assert_flash_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_sel == 2'd0 || flash_sel == 2'd3) |=> flash_di == '0);

  assert_uart_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_owner[2*TXP +: 2] == 2'd2 |-> (pad_oe[TXP] && !pad_oe[RXP]));

  assert_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> (pad_owner[2*FL0 +: 2] == 2'd3 && flash_di == '0));

  for (genvar p = 0; p < NPAD; p++) begin : g_gpio
    assert_gpio_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pad_owner[2*p +: 2] == 2'd0 |-> (pad_do[p] == gpio_do[p] && pad_oe[p] == gpio_oe[p]));
  end
endmodule

bind fgroup_padmux fgroup_padmux_chk #(
  .PIN_BASE(PIN_BASE), .NPAD(NPAD), .FLASH_W(FLASH_W), .EMMC_W(EMMC_W)
) u_chk (.*);

// File: tb/tb_fgroup_padmux.sv
module tb_fgroup_padmux;
  localparam int CLK_PERIOD = 10;
  localparam int NPAD = 27;
  localparam int ITER = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] flash_sel = '0;
  logic uart_sel = 1'b0, emmc_sel = 1'b0, uart_tx = 1'b0;
  logic [NPAD-1:0] gpio_do = '0, gpio_oe = '0, pad_di = '0;
  logic [3:0] flash_do = '0, flash_oe = '0;
  logic [9:0] emmc_do = '0, emmc_oe = '0;
  logic [NPAD-1:0] pad_do, pad_oe;
  logic [2*NPAD-1:0] pad_owner;
  logic [3:0] flash_di;
  logic uart_rx, overlap;
  logic [9:0] emmc_di;

  int errors = 0, checks = 0;
  bit done = 0;

  fgroup_padmux dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int flash_pin(int k, logic [1:0] fs);
    int hi [4] = '{83, 84, 86, 87};
    int lo [4] = '{76, 78, 79, 81};
    return (fs == 2'd1) ? hi[k] : lo[k];
  endfunction

  function automatic int flash_idx(int pin);
    case (pin)
      83, 76: return 0;
      84, 78: return 1;
      86, 79: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] ex_owner(int pin, logic [1:0] fs, logic u, logic e);
    if (u && (pin == 88 || pin == 89)) return 2'd2;
    if (e && pin >= 72 && pin <= 81) return 2'd3;
    if (fs == 2'd1 && (pin == 83 || pin == 84 || pin == 86 || pin == 87)) return 2'd1;
    if (fs == 2'd2 && (pin == 76 || pin == 78 || pin == 79 || pin == 81)) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(logic [1:0] fs, logic u, logic e);
    for (int p = 0; p < NPAD; p++) begin
      int pin = 72 + p;
      logic [1:0] o = ex_owner(pin, fs, u, e);
      logic d, oe;
      string tag;
      case (o)
        2'd0: begin d = gpio_do[p]; oe = gpio_oe[p];
                tag = (fs == 2'd1 || fs == 2'd2) ? "R9 gpio pad" : "R5 flash off, gpio pad"; end
        2'd1: begin d = flash_do[flash_idx(pin)]; oe = flash_oe[flash_idx(pin)];
                tag = (fs == 2'd1) ? "R3 flash hi pad" : "R4 flash lo pad"; end
        2'd2: begin d = (pin == 88) ? uart_tx : 1'b0; oe = (pin == 88); tag = "R6 uart pad"; end
        default: begin d = emmc_do[pin-72]; oe = emmc_oe[pin-72];
                tag = (fs == 2'd2 && (pin == 76 || pin == 78 || pin == 79 || pin == 81))
                      ? "R8 overlap pad" : "R7 emmc pad"; end
      endcase
      chk($sformatf("%s pin%0d owner", tag, pin), 64'(pad_owner[2*p +: 2]), 64'(o));
      chk($sformatf("%s pin%0d do/oe", tag, pin), 64'({pad_do[p], pad_oe[p]}), 64'({d, oe}));
    end
    begin
      logic [3:0] fd = '0;
      for (int k = 0; k < 4; k++)
        if (fs == 2'd1 || (fs == 2'd2 && !e)) fd[k] = pad_di[flash_pin(k, fs) - 72];
      chk((fs == 2'd1) ? "R3 flash_di" : (fs == 2'd2 ? (e ? "R8 flash_di" : "R4 flash_di") : "R5 flash_di"),
          64'(flash_di), 64'(fd));
    end
    chk("R7 emmc_di", 64'(emmc_di), 64'(e ? pad_di[9:0] : 10'd0));
    chk("R6 uart_rx", 64'(uart_rx), 64'(u ? pad_di[17] : 1'b1));
    chk("R8 overlap", 64'(overlap), 64'(fs == 2'd2 && e));
  endtask

  task automatic drive(logic [1:0] fs, logic u, logic e);
    @(negedge clk);
    flash_sel = fs; uart_sel = u; emmc_sel = e;
    gpio_do = NPAD'({$urandom, $urandom}); gpio_oe = NPAD'({$urandom, $urandom});
    pad_di = NPAD'({$urandom, $urandom});
    flash_do = 4'($urandom); flash_oe = 4'($urandom);
    emmc_do = 10'($urandom); emmc_oe = 10'($urandom);
    uart_tx = 1'($urandom);
    @(posedge clk); #1;
    check_all(fs, u, e);
  endtask

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    gpio_do = 27'h5a5a5a5; gpio_oe = 27'h3c3c3c3;
    #(CLK_PERIOD*2 + 1);
    chk("R1 owner in reset", 64'(pad_owner), 64'd0);
    chk("R1 do in reset", 64'(pad_do), 64'(gpio_do));
    chk("R1 oe in reset", 64'(pad_oe), 64'(gpio_oe));
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 owner after reset", 64'(pad_owner), 64'd0);
    chk("R1 overlap after reset", 64'(overlap), 64'd0);
    // R2: control not visible before the edge, visible after
    @(negedge clk); emmc_sel = 1'b1; flash_sel = 2'd2; #1;
    chk("R2 emmc not yet owned", 64'(pad_owner[1:0]), 64'd0);
    chk("R2 overlap not yet", 64'(overlap), 64'd0);
    @(posedge clk); #1;
    chk("R2 emmc owned after edge", 64'(pad_owner[1:0]), 64'd3);
    // directed corners
    drive(2'd1, 1'b0, 1'b0);
    drive(2'd2, 1'b0, 1'b0);
    drive(2'd2, 1'b0, 1'b1);
    drive(2'd3, 1'b0, 1'b0);
    drive(2'd0, 1'b1, 1'b0);
    drive(2'd1, 1'b1, 1'b1);
    drive(2'd2, 1'b1, 1'b1);
    drive(2'd0, 1'b0, 1'b0);
    for (int i = 0; i < ITER; i++)
      drive(2'($urandom), 1'($urandom), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule